// File: doc/BRIEF.md
# Sprite Page Copy Engine

This engine fills the sprite attribute memory from an ordinary page of processor address space. Software stores a page number to one fixed trigger address. From then on the engine masters the shared bus, reads the 256 bytes of that page in ascending order and pushes each byte into the sprite memory data register. That register's own address pointer advances by one per byte, so a full transfer leaves it back where it started.

The processor clock alternates between read-phase and write-phase cycles, and the engine tracks this with a one-bit flag. Source reads happen only in read-phase cycles. Each byte is held for one cycle and written in the write-phase cycle that follows. The store that fires the trigger completes normally. The halt output then stops the processor from the next cycle until the final sprite write is done, so execution resumes with the following instruction. The total busy time depends on the phase of the trigger cycle: 514 cycles from a read-phase trigger and 513 from a write-phase trigger. The engine raises a request to a bus arbiter while it holds the processor. A withheld grant postpones the pending read to a later read-phase cycle.

Top module: `sprdma_engine`

## Requirements
- R1: A write with `cpu_wr_en` high to address 0x4014 starts a transfer whose source addresses are `{cpu_wr_data, idx}` (page in the upper 8 bits, `idx` in the lower 8 bits). A transfer always begins at `idx` = 0, including the first one after a reset.
- R2: One transfer makes exactly 256 source reads with `idx` rising 0, 1, …, 255, and exactly 256 sprite writes. A sprite address pointer that steps by one per write ends where it began.
- R3: `cpu_phase` is 0 (read phase) in the first cycle after reset and changes value every cycle. `rd_strobe` is high only when `cpu_phase` is 0, and `spr_wr_en` is high only when `cpu_phase` is 1.
- R4: Every sprite write falls in the cycle right after a source read and carries the byte returned by that read.
- R5: With `bus_gnt` held high, `dma_busy` is high for exactly 514 consecutive cycles when the trigger cycle has `cpu_phase` = 0, counting the trigger cycle itself.
- R6: With `bus_gnt` held high, `dma_busy` is high for exactly 513 consecutive cycles when the trigger cycle has `cpu_phase` = 1.
- R7: `cpu_halt` is low during the trigger cycle and high from the next cycle. It stays high through the cycle of the last sprite write and drops in the same cycle as `dma_busy`.
- R8: `bus_req` equals `cpu_halt`. `rd_strobe` is high only while `bus_gnt` is high. Each read-phase cycle of the halt in which the grant is withheld adds exactly 2 cycles to the busy time.
- R9: A write to any other address does not start a transfer. A write to 0x4014 while a transfer is running does not change the source page or the sequence.
- R10: A synchronous reset clears busy, halt, the byte counter and the phase flag (back to the read phase) at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_wr_en | input | 1 | Processor register write strobe |
| cpu_wr_addr | input | 16 | Processor write address |
| cpu_wr_data | input | 8 | Processor write data; its value is the source page at the trigger address |
| dma_busy | output | 1 | High from the trigger cycle through the last sprite write |
| cpu_halt | output | 1 | Holds the processor off the bus; starts one cycle after the trigger |
| cpu_phase | output | 1 | Cycle phase flag: 0 read phase, 1 write phase |
| bus_req | output | 1 | Request to the shared-bus arbiter |
| bus_gnt | input | 1 | Grant from the arbiter |
| rd_addr | output | 16 | Source read address |
| rd_strobe | output | 1 | Source read in this cycle |
| rd_data | input | 8 | Source data, valid in the cycle of `rd_strobe` |
| spr_wr_en | output | 1 | Write into the sprite memory data register |
| spr_wr_data | output | 8 | Byte for the sprite memory |

## Verification
Outputs are due at different times after the trigger. `dma_busy` rises combinationally in the trigger cycle and `cpu_halt` follows one cycle later. The first source read comes one cycle after the trigger from a write-phase trigger and two cycles after from a read-phase trigger. Each sprite write comes exactly one cycle after its read, and busy drops in the cycle after the last write. The bench drives inputs on the falling edge and samples every output one time unit later, in the middle of the cycle. Busy time is counted cycle by cycle from the trigger cycle, and each withheld read slot adds two cycles to the expected total. A mid-cycle monitor checks phase alternation, address order and the data carried by each write against a source pattern computed arithmetically from page and index.

// File: rtl/sprdma_pkg.sv
package sprdma_pkg;

   // Phase of the current processor cycle; the encoding is visible on cpu_phase.
   typedef enum logic {
      PH_READ  = 1'b0,
      PH_WRITE = 1'b1
   } phase_e;

   function automatic phase_e phase_next(input phase_e cur);
      return (cur == PH_READ) ? PH_WRITE : PH_READ;
   endfunction

endpackage

// File: rtl/sprdma_phase.sv
module sprdma_phase
   import sprdma_pkg::*;
#(
   parameter phase_e START_PHASE = PH_READ
) (
   input  logic   clk,
   input  logic   rst,
   output phase_e phase
);

   phase_e phase_q;

   always_ff @(posedge clk) begin
      if (rst) phase_q <= START_PHASE;
      else     phase_q <= phase_next(phase_q);
   end

   assign phase = phase_q;

   AST_PHASE_TOGGLES: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (phase_q != $past(phase_q))); // R3

endmodule

// File: rtl/sprdma_trigger.sv
module sprdma_trigger #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned PAGE_W    = 8,
   parameter int unsigned DEC_W     = 16,
   parameter int unsigned TRIG_ADDR = 'h4014
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              busy_q,
   output logic              start,
   output logic [PAGE_W-1:0] page
);

   localparam logic [ADDR_W-1:0] TRIG_A = ADDR_W'(TRIG_ADDR);

   logic              hit;
   logic [PAGE_W-1:0] page_q;

   generate
      if (DEC_W >= ADDR_W) begin : g_full_decode
         assign hit = (wr_addr == TRIG_A);
      end else begin : g_partial_decode
         assign hit = (wr_addr[DEC_W-1:0] == TRIG_A[DEC_W-1:0]);
      end
   endgenerate

   assign start = wr_en && hit && !busy_q;

   always_ff @(posedge clk) begin
      if (rst)        page_q <= '0;
      else if (start) page_q <= wr_data[PAGE_W-1:0];
   end

   assign page = page_q;

   AST_PAGE_HELD: assert property (@(posedge clk) disable iff (rst)
      (busy_q && $past(busy_q) && !$past(rst)) |-> $stable(page_q)); // R9

endmodule

// File: rtl/sprdma_seq.sv
module sprdma_seq
   import sprdma_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned PAGE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  phase_e            phase,
   input  logic [PAGE_W-1:0] page,
   input  logic              bus_gnt,
   input  logic [DATA_W-1:0] rd_data,
   output logic              busy_q,
   output logic              rd_strobe,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              spr_wr_en,
   output logic [DATA_W-1:0] spr_wr_data
);

   logic              run_q;
   logic              have_q;
   logic [CNT_W-1:0]  idx_q;
   logic [DATA_W-1:0] byte_q;
   logic              rd_fire;
   logic              wr_fire;

   assign rd_fire = run_q && (phase == PH_READ) && bus_gnt && !have_q;
   assign wr_fire = run_q && (phase == PH_WRITE) && have_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q  <= 1'b0;
         have_q <= 1'b0;
         idx_q  <= '0;
         byte_q <= '0;
      end else begin
         if (start) begin
            run_q  <= 1'b1;
            have_q <= 1'b0;
            idx_q  <= '0;
         end
         if (rd_fire) begin
            byte_q <= rd_data;
            have_q <= 1'b1;
         end
         if (wr_fire) begin
            have_q <= 1'b0;
            idx_q  <= idx_q + CNT_W'(1);
            if (idx_q == {CNT_W{1'b1}}) run_q <= 1'b0;
         end
      end
   end

   assign busy_q      = run_q;
   assign rd_strobe   = rd_fire;
   assign rd_addr     = {page, idx_q};
   assign spr_wr_en   = wr_fire;
   assign spr_wr_data = byte_q;

   AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
      wr_fire |-> $past(rd_fire)); // R4

   AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (rst)
      rd_fire |=> wr_fire); // R4

   AST_END_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
      ($fell(run_q) && !$past(rst)) |-> $past(wr_fire)); // R7

endmodule

// File: rtl/sprdma_engine.sv
module sprdma_engine
   import sprdma_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned DEC_W       = 16,
   parameter int unsigned TRIG_ADDR   = 'h4014,
   parameter phase_e      START_PHASE = PH_READ
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cpu_wr_en,
   input  logic [ADDR_W-1:0] cpu_wr_addr,
   input  logic [DATA_W-1:0] cpu_wr_data,
   output logic              dma_busy,
   output logic              cpu_halt,
   output logic              cpu_phase,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              rd_strobe,
   input  logic [DATA_W-1:0] rd_data,
   output logic              spr_wr_en,
   output logic [DATA_W-1:0] spr_wr_data
);

   localparam int unsigned PAGE_W = ADDR_W - CNT_W;

   generate
      if (CNT_W < 1 || CNT_W >= ADDR_W) begin : g_bad_cnt
         $error("CNT_W must lie between 1 and ADDR_W-1");
      end
      if (PAGE_W > DATA_W) begin : g_bad_page
         $error("page number must fit in one data word");
      end
      if (DEC_W < 1 || DEC_W > ADDR_W) begin : g_bad_dec
         $error("DEC_W must lie between 1 and ADDR_W");
      end
      if (ADDR_W < 32 && TRIG_ADDR >= (32'd1 << ADDR_W)) begin : g_bad_trig
         $error("TRIG_ADDR does not fit in ADDR_W bits");
      end
   endgenerate

   phase_e            phase;
   logic              start;
   logic              busy_q;
   logic [PAGE_W-1:0] page;

   sprdma_phase #(
      .START_PHASE(START_PHASE)
   ) u_phase (
      .clk  (clk),
      .rst  (rst),
      .phase(phase)
   );

   sprdma_trigger #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .PAGE_W   (PAGE_W),
      .DEC_W    (DEC_W),
      .TRIG_ADDR(TRIG_ADDR)
   ) u_trigger (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (cpu_wr_en),
      .wr_addr(cpu_wr_addr),
      .wr_data(cpu_wr_data),
      .busy_q (busy_q),
      .start  (start),
      .page   (page)
   );

   sprdma_seq #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .CNT_W (CNT_W),
      .PAGE_W(PAGE_W)
   ) u_seq (
      .clk        (clk),
      .rst        (rst),
      .start      (start),
      .phase      (phase),
      .page       (page),
      .bus_gnt    (bus_gnt),
      .rd_data    (rd_data),
      .busy_q     (busy_q),
      .rd_strobe  (rd_strobe),
      .rd_addr    (rd_addr),
      .spr_wr_en  (spr_wr_en),
      .spr_wr_data(spr_wr_data)
   );

   assign dma_busy  = busy_q | start;
   assign cpu_halt  = busy_q;
   assign bus_req   = busy_q;
   assign cpu_phase = phase;

   AST_HALT_FOLLOWS_TRIGGER: assert property (@(posedge clk) disable iff (rst)
      start |=> cpu_halt); // R7

   AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (!cpu_halt && (phase == START_PHASE))); // R10

endmodule

// File: tb/sim_sprdma_engine.sv
module sim_sprdma_engine;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cpu_wr_en = 1'b0;
   logic [15:0] cpu_wr_addr = 16'h0000;
   logic [7:0]  cpu_wr_data = 8'h00;
   logic        dma_busy, cpu_halt, cpu_phase, bus_req;
   logic        bus_gnt = 1'b1;
   logic [15:0] rd_addr;
   logic        rd_strobe;
   logic [7:0]  rd_data;
   logic        spr_wr_en;
   logic [7:0]  spr_wr_data;

   int checks = 0;
   int fails  = 0;

   // Source pattern, computed from page and index
   function automatic logic [7:0] src(input logic [7:0] pg, input logic [7:0] ix);
      return (ix + pg * 8'd3) ^ 8'hC3;
   endfunction

   assign rd_data = src(rd_addr[15:8], rd_addr[7:0]);

   always #2.5 clk = ~clk;

   sprdma_engine u0 (
      .clk(clk), .rst(rst),
      .cpu_wr_en(cpu_wr_en), .cpu_wr_addr(cpu_wr_addr), .cpu_wr_data(cpu_wr_data),
      .dma_busy(dma_busy), .cpu_halt(cpu_halt), .cpu_phase(cpu_phase),
      .bus_req(bus_req), .bus_gnt(bus_gnt),
      .rd_addr(rd_addr), .rd_strobe(rd_strobe), .rd_data(rd_data),
      .spr_wr_en(spr_wr_en), .spr_wr_data(spr_wr_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Sprite memory model with a self-incrementing pointer
   logic [7:0] oam [256];
   int   oam_ptr = 0;
   logic [7:0] cur_page = 8'h00;
   int   exp_rd = 0;
   int   exp_wr = 0;
   int   missed = 0;
   logic prev_rst = 1'b1;
   logic prev_phase = 1'b0;
   logic prev_rd = 1'b0;

   // Mid-cycle monitor
   always begin
      @(negedge clk);
      #1;
      if (!rst) begin
         if (!prev_rst) chk(cpu_phase != prev_phase, "R3 phase toggle", cpu_phase, !prev_phase);
         chk(bus_req == cpu_halt, "R8 req equals halt", bus_req, cpu_halt);
         if (rd_strobe) begin
            chk(cpu_phase == 1'b0, "R3 read phase", cpu_phase, 0);
            chk(bus_gnt && cpu_halt, "R8 read needs grant", {bus_gnt, cpu_halt}, 3);
            chk(exp_rd < 256 && rd_addr == {cur_page, 8'(exp_rd)}, "R1 R2 source address",
                rd_addr, {cur_page, 8'(exp_rd)});
            exp_rd++;
         end
         if (spr_wr_en) begin
            chk(cpu_phase == 1'b1, "R3 write phase", cpu_phase, 1);
            chk(prev_rd, "R4 write after read", prev_rd, 1);
            chk(spr_wr_data == src(cur_page, 8'(exp_wr)), "R4 written byte",
                spr_wr_data, src(cur_page, 8'(exp_wr)));
            oam[oam_ptr] = spr_wr_data;
            oam_ptr = (oam_ptr + 1) % 256;
            exp_wr++;
         end
         if (cpu_halt && cpu_phase == 1'b0 && !bus_gnt) missed++;
      end
      prev_rst   = rst;
      prev_phase = cpu_phase;
      prev_rd    = rd_strobe;
   end

   task automatic run_xfer(input logic [7:0] pg, input logic want_phase,
                           input int gap_start, input int gap_len, input bit retrig);
      int start_ptr;
      int busy_cnt;
      int expect_cnt;
      int bad;
      @(negedge clk);
      while (cpu_phase !== want_phase) @(negedge clk);
      cur_page  = pg;
      exp_rd    = 0;
      exp_wr    = 0;
      missed    = 0;
      start_ptr = (pg * 3 + 17) % 256;
      oam_ptr   = start_ptr;
      for (int i = 0; i < 256; i++) oam[i] = 8'h00;
      cpu_wr_en   = 1'b1;
      cpu_wr_addr = 16'h4014;
      cpu_wr_data = pg;
      bus_gnt     = 1'b1;
      #1;
      chk(dma_busy == 1'b1, "R5 busy in trigger cycle", dma_busy, 1);
      chk(cpu_halt == 1'b0, "R7 no halt in trigger cycle", cpu_halt, 0);
      busy_cnt = 1;
      for (int c = 1; c < 3000; c++) begin
         @(negedge clk);
         cpu_wr_en   = (retrig && c == 100);
         cpu_wr_data = pg ^ 8'hFF;
         bus_gnt     = !(c >= gap_start && c < gap_start + gap_len);
         #1;
         if (!dma_busy) begin
            chk(cpu_halt == 1'b0, "R7 halt drops with busy", cpu_halt, 0);
            break;
         end
         busy_cnt++;
         if (cpu_halt !== 1'b1) chk(1'b0, "R7 halt held", cpu_halt, 1);
      end
      cpu_wr_en = 1'b0;
      bus_gnt   = 1'b1;
      expect_cnt = (want_phase == 1'b0 ? 514 : 513) + 2 * missed;
      chk(busy_cnt == expect_cnt, want_phase ? "R6 R8 busy length" : "R5 R8 busy length",
          busy_cnt, expect_cnt);
      chk(exp_rd == 256, "R2 read count", exp_rd, 256);
      chk(exp_wr == 256, "R2 write count", exp_wr, 256);
      chk(oam_ptr == start_ptr, "R2 pointer wrap", oam_ptr, start_ptr);
      bad = 0;
      for (int i = 0; i < 256; i++)
         if (oam[(start_ptr + i) % 256] !== src(pg, 8'(i))) bad++;
      chk(bad == 0, retrig ? "R9 R1 sprite contents" : "R1 sprite contents", bad, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      #1;
      chk(!dma_busy && !cpu_halt && !bus_req, "R10 reset outputs",
          {dma_busy, cpu_halt, bus_req}, 0);
      chk(!rd_strobe && !spr_wr_en, "R10 reset strobes", {rd_strobe, spr_wr_en}, 0);
      chk(cpu_phase == 1'b0, "R10 reset phase", cpu_phase, 0);
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk(cpu_phase == 1'b0, "R3 first phase is read", cpu_phase, 0);

      // R9: writes to other addresses start nothing
      @(negedge clk);
      cpu_wr_en = 1'b1; cpu_wr_addr = 16'h4015; cpu_wr_data = 8'h12;
      #1;
      chk(dma_busy == 1'b0, "R9 other address", dma_busy, 0);
      @(negedge clk);
      cpu_wr_addr = 16'hC014;
      #1;
      chk(dma_busy == 1'b0, "R9 other address high bits", dma_busy, 0);
      @(negedge clk);
      cpu_wr_en = 1'b0;
      #1;
      chk(!dma_busy && !cpu_halt, "R9 stays idle", {dma_busy, cpu_halt}, 0);

      // Sweep over pages and both trigger phases (R5, R6)
      for (int i = 0; i < 40; i++) run_xfer(8'(i * 37 + 1), 1'(i % 2), 0, 0, 1'b0);
      run_xfer(8'h00, 1'b0, 0, 0, 1'b0);
      run_xfer(8'hFF, 1'b1, 0, 0, 1'b0);

      // Withheld grant (R8) and retrigger during a transfer (R9)
      run_xfer(8'h02, 1'b0, 5, 9, 1'b0);
      run_xfer(8'hA5, 1'b1, 200, 30, 1'b1);
      run_xfer(8'h80, 1'b1, 0, 0, 1'b1);

      // R10: reset in the middle of a transfer, then a fresh full transfer
      @(negedge clk);
      while (cpu_phase !== 1'b0) @(negedge clk);
      cur_page = 8'h3C; exp_rd = 0; exp_wr = 0;
      cpu_wr_en = 1'b1; cpu_wr_addr = 16'h4014; cpu_wr_data = 8'h3C;
      @(negedge clk);
      cpu_wr_en = 1'b0;
      repeat (60) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      #1;
      chk(!dma_busy && !cpu_halt && !rd_strobe && !spr_wr_en, "R10 reset aborts",
          {dma_busy, cpu_halt, rd_strobe, spr_wr_en}, 0);
      chk(cpu_phase == 1'b0, "R10 phase cleared", cpu_phase, 0);
      @(negedge clk);
      rst = 1'b0;
      run_xfer(8'h44, 1'b0, 0, 0, 1'b0);
      run_xfer(8'h45, 1'b1, 0, 0, 1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule